// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer Adder

This block adds two vectors of packed integers in one registered stage. Each operand bus is 128 bits wide and is cut into independent lanes of 8, 16, 32 or 64 bits. Carries never cross a lane boundary. The lane size, the signedness and a clamp option are chosen for each operation.

Four operand shapes share the single adder datapath:

- **Normal:** same-size lanes in, same-size lanes out, on a 64-bit or a 128-bit vector.
- **Long:** two 64-bit sources whose lanes are widened to twice their width, giving a 128-bit result.
- **Wide:** a 128-bit source of double-width lanes plus a 64-bit source of single-width lanes that are widened first.
- **Narrow:** two 128-bit sources whose sums are reduced to half-width lanes in a 64-bit result.

The result, an error flag and a valid strobe appear one clock after the operation is presented.

Top module: `simd_add_unit`

## Requirements
- R1: Encodings are as follows. `lane_code` 0/1/2/3 selects 8/16/32/64-bit source lanes. `shape_code` 0/1/2/3 selects normal/long/wide/narrow. In normal shape each lane result is (a+b) modulo 2^W, and no carry passes from one lane into the next.
- R2: In normal shape with `quad_sel`=0, only bits 63:0 of the operands are used and `res_data[127:64]` is zero. With `quad_sel`=1 all 128 bits take part. `quad_sel` has no effect in the other shapes.
- R3: In long shape, lane i of `op_a[63:0]` and lane i of `op_b[63:0]` are each extended to 2W bits, with sign extension when `signed_mode`=1 and zero extension otherwise. Their sum fills lane i of a 128-bit result of 2W-bit lanes.
- R4: In wide shape, `op_a` is read as 2W-bit lanes. Lane i of `op_b[63:0]` (W bits) is extended per `signed_mode` and added to lane i of `op_a`, giving a 128-bit result of 2W-bit lanes.
- R5: In narrow shape with `sat_mode`=0, lane i of the result holds the low W/2 bits of the W-bit sum of lane i of both 128-bit operands. The result is packed in `res_data[63:0]`, and `res_data[127:64]` is zero.
- R6: With `sat_mode`=1 and `signed_mode`=1 in normal, long or wide shape, a lane sum that overflows is replaced by the most positive value of the lane (when both addends are non-negative) or by the most negative value (when both are negative).
- R7: With `sat_mode`=1 and `signed_mode`=0 in normal, long or wide shape, a lane sum that carries out of the lane is replaced by all ones.
- R8: In narrow shape with `sat_mode`=1, the exact sum of the two W-bit lanes is clamped into the W/2-bit range: the signed range when `signed_mode`=1, and 0 up to all ones otherwise.
- R9: Long or wide shape with `lane_code`=3, and narrow shape with `lane_code`=0, are illegal. These raise `res_err` and give `res_data` equal to zero. Every legal combination gives `res_err`=0.
- R10: `res_valid` is `in_valid` delayed by one clock. When `in_valid` is low, `res_data` and `res_err` hold their previous values.
- R11: While `rst_n` is low, `res_data`, `res_valid` and `res_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op_a | input | 128 | First source vector |
| op_b | input | 128 | Second source vector |
| lane_code | input | 2 | Source lane width: 0=8, 1=16, 2=32, 3=64 bits |
| shape_code | input | 2 | 0 normal, 1 long, 2 wide, 3 narrow |
| quad_sel | input | 1 | Normal shape only: 1 = 128-bit vector, 0 = 64-bit vector |
| signed_mode | input | 1 | Lanes are two's complement when 1 |
| sat_mode | input | 1 | Clamp lane results instead of wrapping |
| res_data | output | 128 | Registered result vector |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_err | output | 1 | Illegal shape/lane combination was requested |

## Verification
The assertions assume that `shape_code` and `lane_code` are stable and meaningful whenever `in_valid` is high. They also assume that `in_valid` is held low during reset, so that the one-cycle tracking of the strobe and the hold of the result start from a known state. The stimulus drives every input at the falling edge from a single task. It holds `in_valid` low in reset and in idle gaps, and draws shapes and lane codes over their full range, illegal pairs included, so every decoded combination is a defined operation.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int VEC_W  = 128;
  localparam int HALF_W = VEC_W / 2;
  localparam int SEG_W  = 8;
  localparam int NSEG   = VEC_W / SEG_W;
  localparam int NSIZE  = 4;

  typedef enum logic [1:0] {SHP_NORMAL = 2'd0, SHP_LONG = 2'd1,
                            SHP_WIDE = 2'd2, SHP_NARROW = 2'd3} shape_e;
  typedef enum logic [1:0] {LW_8 = 2'd0, LW_16 = 2'd1,
                            LW_32 = 2'd2, LW_64 = 2'd3} lane_e;

  // Shape/lane pairs that have no defined result width
  function automatic logic combo_illegal(shape_e s, lane_e l);
    return ((s == SHP_LONG || s == SHP_WIDE) && l == LW_64) ||
           (s == SHP_NARROW && l == LW_8);
  endfunction

  // Width code at which the adder itself operates
  function automatic logic [1:0] adder_code(shape_e s, lane_e l);
    if ((s == SHP_LONG || s == SHP_WIDE) && l != LW_64)
      return 2'(l) + 2'd1;
    return 2'(l);
  endfunction

  // Clamp value for a lane of width w (w <= 64), low-aligned
  function automatic logic [63:0] clamp_value(logic neg_side, logic sgn, int w);
    logic [64:0] t;
    if (sgn) begin
      t = (65'd1 << (w - 1));
      if (!neg_side) t = t - 65'd1;
    end else begin
      t = neg_side ? 65'd0 : ((65'd1 << w) - 65'd1);
    end
    return t[63:0];
  endfunction
endpackage

// File: rtl/simd_operand_prep.sv
module simd_operand_prep
  import simd_add_pkg::*;
(
  input  logic [VEC_W-1:0] a_in,
  input  logic [VEC_W-1:0] b_in,
  input  shape_e           shape,
  input  lane_e            lane,
  input  logic             quad,
  input  logic             sgn,
  output logic [VEC_W-1:0] x_out,
  output logic [VEC_W-1:0] y_out
);
  localparam int NEXT = 3;

  logic [VEC_W-1:0] ext_a [NEXT];
  logic [VEC_W-1:0] ext_b [NEXT];

  // Widen the low half into double-width lanes for every legal source size
  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    localparam int W  = SEG_W << k;
    localparam int NL = HALF_W / W;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      assign ext_a[k][i*2*W +: 2*W] = {{W{sgn & a_in[i*W+W-1]}}, a_in[i*W +: W]};
      assign ext_b[k][i*2*W +: 2*W] = {{W{sgn & b_in[i*W+W-1]}}, b_in[i*W +: W]};
    end
  end

  logic [1:0]       ext_sel;
  logic [VEC_W-1:0] keep_mask;

  always_comb begin
    ext_sel   = (lane == LW_64) ? 2'd0 : 2'(lane);
    keep_mask = quad ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    unique case (shape)
      SHP_NORMAL: begin
        x_out = a_in & keep_mask;
        y_out = b_in & keep_mask;
      end
      SHP_LONG: begin
        x_out = ext_a[ext_sel];
        y_out = ext_b[ext_sel];
      end
      SHP_WIDE: begin
        x_out = a_in;
        y_out = ext_b[ext_sel];
      end
      default: begin
        x_out = a_in;
        y_out = b_in;
      end
    endcase
  end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_add_pkg::*;
(
  input  logic [VEC_W-1:0] x_in,
  input  logic [VEC_W-1:0] y_in,
  input  logic [1:0]       width_code,
  output logic [VEC_W-1:0] sum_out,
  output logic [NSEG-1:0]  seg_cout,
  output logic [NSEG-1:0]  seg_break
);
  logic [3:0] grp_mask;

  // A segment starts a lane when its index is a multiple of the lane's segment count
  always_comb begin
    grp_mask = (4'd1 << width_code) - 4'd1;
    for (int j = 0; j < NSEG; j++)
      seg_break[j] = ((4'(j) & grp_mask) == 4'd0);
  end

  always_comb begin
    logic carry;
    logic [SEG_W:0] part;
    carry = 1'b0;
    for (int j = 0; j < NSEG; j++) begin
      if (seg_break[j]) carry = 1'b0;
      part = {1'b0, x_in[j*SEG_W +: SEG_W]} + {1'b0, y_in[j*SEG_W +: SEG_W]}
             + {{SEG_W{1'b0}}, carry};
      sum_out[j*SEG_W +: SEG_W] = part[SEG_W-1:0];
      carry = part[SEG_W];
      seg_cout[j] = carry;
    end
  end
endmodule

// File: rtl/simd_lane_fix.sv
module simd_lane_fix
  import simd_add_pkg::*;
(
  input  logic [VEC_W-1:0]  x_in,
  input  logic [VEC_W-1:0]  y_in,
  input  logic [VEC_W-1:0]  sum_in,
  input  logic [NSEG-1:0]   seg_cout,
  input  logic [1:0]        width_code,
  input  logic              sgn,
  input  logic              sat,
  output logic [VEC_W-1:0]  full_res,
  output logic [HALF_W-1:0] nar_res
);
  logic [VEC_W-1:0]  full_v [NSIZE];
  logic [HALF_W-1:0] nar_v  [NSIZE];

  for (genvar e = 0; e < NSIZE; e++) begin : g_size
    localparam int E  = SEG_W << e;
    localparam int NL = VEC_W / E;
    localparam int H  = E / 2;
    logic [VEC_W-1:0] fv;

    // Same-width result: wrap or clamp
    always_comb begin
      logic a_msb, b_msb, s_msb, ovf;
      logic [63:0] pk;
      for (int i = 0; i < NL; i++) begin
        a_msb = x_in[i*E+E-1];
        b_msb = y_in[i*E+E-1];
        s_msb = sum_in[i*E+E-1];
        ovf   = sgn ? ((a_msb == b_msb) && (s_msb != a_msb))
                    : seg_cout[(i+1)*(E/SEG_W)-1];
        pk    = clamp_value(sgn & a_msb, sgn, E);
        fv[i*E +: E] = (sat && ovf) ? pk[E-1:0] : sum_in[i*E +: E];
      end
    end
    assign full_v[e] = fv;

    if (E >= 2*SEG_W) begin : g_nar
      logic [HALF_W-1:0] nv;
      // Half-width result: keep low half or clamp the exact sum
      always_comb begin
        logic a_msb, b_msb, s_msb, ovf, neg, fits;
        logic [63:0] pk;
        for (int i = 0; i < NL; i++) begin
          a_msb = x_in[i*E+E-1];
          b_msb = y_in[i*E+E-1];
          s_msb = sum_in[i*E+E-1];
          if (sgn) begin
            ovf  = (a_msb == b_msb) && (s_msb != a_msb);
            neg  = ovf ? a_msb : s_msb;
            fits = !ovf && (sum_in[i*E+H-1 +: H+1] == {(H+1){s_msb}});
          end else begin
            ovf  = seg_cout[(i+1)*(E/SEG_W)-1];
            neg  = 1'b0;
            fits = !ovf && (sum_in[i*E+H +: H] == '0);
          end
          pk = clamp_value(neg, sgn, H);
          nv[i*H +: H] = (sat && !fits) ? pk[H-1:0] : sum_in[i*E +: H];
        end
      end
      assign nar_v[e] = nv;
    end else begin : g_no_nar
      assign nar_v[e] = '0;
    end
  end

  assign full_res = full_v[width_code];
  assign nar_res  = nar_v[width_code];
endmodule

// File: rtl/simd_add_unit.sv
module simd_add_unit
  import simd_add_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] op_a,
  input  logic [127:0] op_b,
  input  logic [1:0]   lane_code,
  input  logic [1:0]   shape_code,
  input  logic         quad_sel,
  input  logic         signed_mode,
  input  logic         sat_mode,
  output logic [127:0] res_data,
  output logic         res_valid,
  output logic         res_err
);
  shape_e shape;
  lane_e  lane;
  assign shape = shape_e'(shape_code);
  assign lane  = lane_e'(lane_code);

  // Named internal events, observed by the checker
  logic             illegal_combo;
  logic [1:0]       add_code;
  logic [NSEG-1:0]  seg_break;
  logic [NSEG-1:0]  seg_cout;
  logic [VEC_W-1:0] x_op, y_op, raw_sum, full_res;
  logic [HALF_W-1:0] nar_res;
  logic [VEC_W-1:0] res_next;

  assign illegal_combo = combo_illegal(shape, lane);
  assign add_code      = adder_code(shape, lane);

  simd_operand_prep u_prep (
    .a_in (op_a), .b_in (op_b), .shape (shape), .lane (lane),
    .quad (quad_sel), .sgn (signed_mode), .x_out (x_op), .y_out (y_op)
  );

  simd_seg_adder u_add (
    .x_in (x_op), .y_in (y_op), .width_code (add_code),
    .sum_out (raw_sum), .seg_cout (seg_cout), .seg_break (seg_break)
  );

  simd_lane_fix u_fix (
    .x_in (x_op), .y_in (y_op), .sum_in (raw_sum), .seg_cout (seg_cout),
    .width_code (add_code), .sgn (signed_mode), .sat (sat_mode),
    .full_res (full_res), .nar_res (nar_res)
  );

  always_comb begin
    if (illegal_combo)
      res_next = '0;
    else if (shape == SHP_NARROW)
      res_next = {{HALF_W{1'b0}}, nar_res};
    else if (shape == SHP_NORMAL && !quad_sel)
      res_next = {{HALF_W{1'b0}}, full_res[HALF_W-1:0]};
    else
      res_next = full_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_data <= res_next;
        res_err  <= illegal_combo;
      end
    end
  end
endmodule

// File: rtl/simd_add_checker.sv
module simd_add_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   shape_code,
  input logic [1:0]   lane_code,
  input logic [127:0] res_data,
  input logic         res_valid,
  input logic         res_err,
  input logic         illegal_combo,
  input logic [1:0]   add_code,
  input logic [15:0]  seg_break
);
  p_valid_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_data) && $stable(res_err)));

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && illegal_combo) |=> (res_err && res_data == 128'd0));

  p_legal_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !illegal_combo) |=> !res_err);

  p_narrow_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shape_code == 2'd3) |=> (res_data[127:64] == 64'd0));

  p_lane_breaks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_break) == (16 >> add_code));

  p_first_seg_break_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_break[0] && (lane_code != 2'd3 || shape_code == 2'd0 || shape_code == 2'd3
                     || !seg_break[8] || add_code == 2'd3));
endmodule

bind simd_add_unit simd_add_checker u_chk (
  .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .shape_code (shape_code),
  .lane_code (lane_code), .res_data (res_data), .res_valid (res_valid),
  .res_err (res_err), .illegal_combo (illegal_combo), .add_code (add_code),
  .seg_break (seg_break)
);

// File: tb/simd_add_unit_test.sv
`timescale 1ns/1ps
module simd_add_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   lane_code = '0, shape_code = '0;
  logic         quad_sel = 1'b0, signed_mode = 1'b0, sat_mode = 1'b0;
  logic [127:0] res_data;
  logic         res_valid, res_err;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  simd_add_unit uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_a (op_a), .op_b (op_b),
    .lane_code (lane_code), .shape_code (shape_code), .quad_sel (quad_sel),
    .signed_mode (signed_mode), .sat_mode (sat_mode),
    .res_data (res_data), .res_valid (res_valid), .res_err (res_err)
  );

  // Read one lane as an exact integer
  function automatic logic signed [65:0] fld(logic [127:0] v, int pos, int w, bit sgn);
    logic [127:0] t;
    logic signed [65:0] r;
    t = (v >> pos) & ((128'd1 << w) - 128'd1);
    r = $signed({2'b00, t[63:0]});
    if (sgn && t[w-1]) r = r - (66'sd1 <<< w);
    return r;
  endfunction

  function automatic logic signed [65:0] clampv(logic signed [65:0] s, int w, bit sgn);
    logic signed [65:0] hi, lo;
    if (sgn) begin
      hi = (66'sd1 <<< (w - 1)) - 66'sd1;
      lo = -(66'sd1 <<< (w - 1));
    end else begin
      hi = (66'sd1 <<< w) - 66'sd1;
      lo = 66'sd0;
    end
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

  // Expected {err, data}
  function automatic logic [128:0] model(logic [127:0] a, logic [127:0] b, int lane,
                                         int shp, bit quad, bit sgn, bit sat);
    int w, n, ow, pa, pb, wa, wb;
    logic [127:0] r;
    logic signed [65:0] s;
    w = 8 << lane;
    r = '0;
    if (((shp == 1 || shp == 2) && lane == 3) || (shp == 3 && lane == 0))
      return {1'b1, 128'd0};
    case (shp)
      0: begin n = (quad ? 128 : 64) / w; ow = w; end
      1, 2: begin n = 64 / w; ow = 2 * w; end
      default: begin n = 128 / w; ow = w / 2; end
    endcase
    for (int i = 0; i < n; i++) begin
      pa = i * w; pb = i * w; wa = w; wb = w;
      if (shp == 2) begin pa = i * 2 * w; wa = 2 * w; end
      s = fld(a, pa, wa, sgn) + fld(b, pb, wb, sgn);
      if (sat) s = clampv(s, ow, sgn);
      r = r | ((128'(s) & ((128'd1 << ow) - 128'd1)) << (i * ow));
    end
    return {1'b0, r};
  endfunction

  task automatic run_op(string tag, logic [127:0] a, logic [127:0] b, int lane,
                        int shp, bit quad, bit sgn, bit sat);
    logic [128:0] exp;
    exp = model(a, b, lane, shp, quad, sgn, sat);
    @(negedge clk);
    op_a = a; op_b = b; lane_code = 2'(lane); shape_code = 2'(shp);
    quad_sel = quad; signed_mode = sgn; sat_mode = sat; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (res_valid !== 1'b1 || res_err !== exp[128] || res_data !== exp[127:0]) begin
      n_fail++;
      $display("FAIL %s: got v=%0b e=%0b d=%h, expected v=1 e=%0b d=%h (lane=%0d shape=%0d q=%0b s=%0b sat=%0b)",
               tag, res_valid, res_err, res_data, exp[128], exp[127:0],
               lane, shp, quad, sgn, sat);
    end
  endtask

  function automatic logic [127:0] pick_vec(int mode);
    logic [127:0] v;
    logic [7:0] bytes [5];
    bytes[0] = 8'h00; bytes[1] = 8'h7F; bytes[2] = 8'h80; bytes[3] = 8'hFF; bytes[4] = 8'h01;
    if (mode == 0) return {$urandom, $urandom, $urandom, $urandom};
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = bytes[$urandom % 5];
    return v;
  endfunction

  function automatic string tag_of(int lane, int shp, bit sgn, bit sat);
    if (((shp == 1 || shp == 2) && lane == 3) || (shp == 3 && lane == 0)) return "R9";
    if (shp == 1) return "R3";
    if (shp == 2) return "R4";
    if (shp == 3) return sat ? "R8" : "R5";
    if (sat) return sgn ? "R6" : "R7";
    return "R1";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [127:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11: reset state
    n_checks++;
    if (res_data !== '0 || res_valid !== 1'b0 || res_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: got d=%h v=%0b e=%0b, expected all zero", res_data, res_valid, res_err);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: carry must stop at every lane boundary
    run_op("R1", {16{8'hFF}}, {16{8'h01}}, 0, 0, 1, 0, 0);
    run_op("R1", {8{16'hFFFF}}, {8{16'h0001}}, 1, 0, 1, 0, 0);
    run_op("R1", {4{32'hFFFF_FFFF}}, {4{32'h1}}, 2, 0, 1, 1, 0);
    run_op("R1", {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, 3, 0, 1, 0, 0);
    // R2: doubleword normal masks the upper half
    run_op("R2", {64'h1234_5678_9ABC_DEF0, 64'h0101_0101_0101_0101},
           {64'hFFFF_0000_FFFF_0000, 64'h0202_0202_0202_0202}, 0, 0, 0, 0, 0);
    // R3: long, signed -1 + -1 in widened lanes, and unsigned max + max
    run_op("R3", {64'h0, {8{8'hFF}}}, {64'h0, {8{8'hFF}}}, 0, 1, 0, 1, 0);
    run_op("R3", {64'h0, {2{32'hFFFF_FFFF}}}, {64'h0, {2{32'hFFFF_FFFF}}}, 2, 1, 1, 0, 1);
    // R4: wide with negative narrow operand
    run_op("R4", {4{32'h0000_0100}}, {64'h0, {4{16'h8000}}}, 1, 2, 0, 1, 0);
    // R5: narrow keeps low half
    run_op("R5", {8{16'h12F0}}, {8{16'h0120}}, 1, 3, 0, 0, 0);
    // R6: signed clamp both directions
    run_op("R6", {8{8'h7F, 8'h80}}, {8{8'h01, 8'hFF}}, 0, 0, 1, 1, 1);
    // R7: unsigned clamp to all ones
    run_op("R7", {8{16'hFFF0}}, {8{16'h0020}}, 1, 0, 1, 0, 1);
    // R8: narrow clamp, signed and unsigned
    run_op("R8", {4{32'h0001_0000, 32'hFFFE_0000}}, {8{32'h0}}, 2, 3, 0, 1, 1);
    run_op("R8", {8{16'h0100}}, {8{16'h0005}}, 1, 3, 0, 0, 1);
    // R9: illegal pairs
    run_op("R9", '1, '1, 3, 1, 1, 1, 1);
    run_op("R9", '1, '1, 0, 3, 1, 0, 0);

    // R10: idle cycle holds the result and drops the strobe
    held = res_data;
    @(negedge clk);
    n_checks++;
    if (res_valid !== 1'b0 || res_data !== held) begin
      n_fail++;
      $display("FAIL R10: got v=%0b d=%h, expected v=0 d=%h", res_valid, res_data, held);
    end

    // Constrained random mix
    for (int t = 0; t < 400; t++) begin
      int ln, sh;
      bit q, sg, st;
      ln = $urandom % 4; sh = $urandom % 4;
      q = 1'($urandom); sg = 1'($urandom); st = 1'($urandom);
      run_op(tag_of(ln, sh, sg, st), pick_vec($urandom % 2), pick_vec($urandom % 2),
             ln, sh, q, sg, st);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule